// File: doc/BRIEF.md
# Delta-Sigma Bitstream Input Decoder

This block sits in front of the decimation filters of a delta-sigma measurement channel. It takes the raw one-bit modulator data line and, where the modulator provides one, its clock line. It turns them into a clean stream of recovered bits in the system clock domain. Each recovered bit is presented as a one-cycle `bit_valid` strobe together with its value on `bit_data`.

Both raw lines pass through two-flop synchronizers, and edges are found by comparing consecutive synchronized samples. A two-bit `mode` input selects how bits are taken. In mode 0 the clock runs at the bit rate and a bit is taken on each rising edge. In mode 1 it runs at half the bit rate and a bit is taken on both edges. In mode 3 it runs at twice the bit rate and a bit is taken on every second rising edge. In mode 2 there is no clock, and the data line is decoded as a Manchester stream whose half-bit period is learned from the spacing of its transitions.

A watchdog counts system cycles without line activity: clock edges in the clocked modes, data transitions in mode 2. When that count reaches `fail_timeout`, it raises `clk_fail`.

Top module: `sd_bit_decoder`

## Requirements
- R1: While reset is low and in the first cycle after its release, `bit_valid` and `clk_fail` are 0.
- R2: Mode 0 (`mode`=0): each rising edge of `mod_clk` yields exactly one `bit_valid` pulse, carrying the level of `mod_data` at that edge. Falling edges yield nothing.
- R3: Mode 1 (`mode`=1): every rising and every falling edge of `mod_clk` yields one bit, carrying the level of `mod_data` at that edge.
- R4: Mode 3 (`mode`=3): only the second, fourth, sixth and later rising edges of `mod_clk` yield a bit. The count restarts at every change of `mode`, and no bit is produced in the cycle after such a change.
- R5: Mode 2 (`mode`=2): `mod_clk` is ignored. A mid-bit rising transition of `mod_data` gives bit 1 and a falling one gives bit 0. Transitions spaced about one half-bit period set the period estimate. A spacing of about two half periods marks a mid-bit transition and locks the decoder. Bits are emitted only from that first lock onward.
- R6: In mode 2, a gap of more than 2.5 estimated half periods between transitions drops the lock. Short transitions that follow the gap then produce no bits until a long spacing is seen again.
- R7: If `fail_timeout` is nonzero and no activity has been seen for `fail_timeout` cycles, `clk_fail` goes to 1. Activity means clock edges in modes 0, 1 and 3, and data transitions in mode 2. The next activity clears `clk_fail`.
- R8: When `fail_timeout` is 0, `clk_fail` stays at 0.
- R9: `clk_fail` is never 1 in a cycle in which `bit_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Strobing scheme: 0 rise, 1 both edges, 2 Manchester, 3 every second rise |
| fail_timeout | input | TO_W | Idle cycles before clock failure; 0 disables |
| mod_clk | input | 1 | Raw modulator clock line |
| mod_data | input | 1 | Raw modulator data line |
| bit_valid | output | 1 | One-cycle strobe for each recovered bit |
| bit_data | output | 1 | Value of the recovered bit |
| clk_fail | output | 1 | Modulator activity missing |

## Verification
The properties assume that `mode` and `fail_timeout` are driven synchronously and settle between system clock edges. They also assume the modulator lines change slowly enough that each edge survives the synchronizers as one distinct sample. The stimulus therefore drives every input on the falling system edge. It keeps modulator edges at least two system cycles apart and holds the data level for at least two cycles before the clock edge that samples it. Manchester streams use a fixed half period of eight system cycles. Each stream starts with a run of equal bits followed by a change of value, so the decoder can learn the period and lock.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
    typedef enum logic [1:0] {
        MODE_RISE  = 2'd0,
        MODE_BOTH  = 2'd1,
        MODE_MANCH = 2'd2,
        MODE_EVERY2 = 2'd3
    } sdd_mode_e;
endpackage

// File: rtl/sdd_sync.sv
module sdd_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/sdd_manch.sv
module sdd_manch #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic trans,
    input  logic level,
    output logic emit,
    output logic emit_bit
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam int XW = CNT_W + 3;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] half;
        logic             locked;
        logic             at_mid;
    } man_t;

    man_t st_d, st_q;
    logic [XW-1:0] iv2, half3, half5;

    always_comb begin
        st_d  = st_q;
        emit  = 1'b0;
        iv2   = XW'(st_q.cnt) << 1;
        half3 = XW'(st_q.half) * XW'(3);
        half5 = XW'(st_q.half) * XW'(5);
        if (restart) begin
            st_d.cnt    = CMAX;
            st_d.half   = CMAX;
            st_d.locked = 1'b0;
            st_d.at_mid = 1'b0;
        end else if (trans) begin
            st_d.cnt = CNT_W'(1);
            if (iv2 > half5) begin
                st_d.locked = 1'b0;
                st_d.at_mid = 1'b0;
                st_d.half   = CMAX;
            end else if (iv2 > half3) begin
                emit        = 1'b1;
                st_d.locked = 1'b1;
                st_d.at_mid = 1'b1;
                st_d.half   = st_q.cnt >> 1;
            end else begin
                st_d.half = st_q.cnt;
                if (st_q.locked) begin
                    if (st_q.at_mid) begin
                        st_d.at_mid = 1'b0;
                    end else begin
                        emit        = 1'b1;
                        st_d.at_mid = 1'b1;
                    end
                end
            end
        end else if (st_q.cnt != CMAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CMAX, half: CMAX, locked: 1'b0, at_mid: 1'b0};
        else        st_q <= st_d;
    end

    assign emit_bit = level;
endmodule

// File: rtl/sdd_watch.sv
module sdd_watch #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            activity,
    input  logic            restart,
    input  logic [TO_W-1:0] timeout,
    output logic            fail
);
    localparam logic [TO_W-1:0] TMAX = '1;

    typedef struct packed {
        logic [TO_W-1:0] cnt;
        logic            fail;
    } wd_t;

    wd_t st_d, st_q;

    always_comb begin
        if (activity || restart)  st_d.cnt = '0;
        else if (st_q.cnt != TMAX) st_d.cnt = st_q.cnt + TO_W'(1);
        else                      st_d.cnt = st_q.cnt;
        st_d.fail = (timeout != '0) && (st_d.cnt >= timeout);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fail = st_q.fail;
endmodule

// File: rtl/sd_bit_decoder.sv
module sd_bit_decoder
    import sdd_pkg::*;
#(
    parameter int TO_W  = 16,
    parameter int CNT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [TO_W-1:0] fail_timeout,
    input  logic            mod_clk,
    input  logic            mod_data,
    output logic            bit_valid,
    output logic            bit_data,
    output logic            clk_fail
);
    typedef struct packed {
        logic      clk_p;
        logic      dat_p;
        sdd_mode_e mode;
        logic      phase;
        logic      valid;
        logic      bitv;
    } top_t;

    top_t st_d, st_q;
    logic [1:0] synced;
    logic c_s, d_s, rise, fall, dtr, chg, take, activity, m_restart, m_emit, m_bit;
    sdd_mode_e cur_mode;

    sdd_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({mod_clk, mod_data}), .dout(synced)
    );

    assign c_s      = synced[1];
    assign d_s      = synced[0];
    assign cur_mode = sdd_mode_e'(mode);
    assign chg      = (cur_mode != st_q.mode);
    assign m_restart = chg || (cur_mode != MODE_MANCH);

    sdd_manch #(.CNT_W(CNT_W)) u_manch (
        .clk(clk), .rst_n(rst_n), .restart(m_restart), .trans(dtr),
        .level(d_s), .emit(m_emit), .emit_bit(m_bit)
    );

    sdd_watch #(.TO_W(TO_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .activity(activity), .restart(chg),
        .timeout(fail_timeout), .fail(clk_fail)
    );

    always_comb begin
        rise  = c_s & ~st_q.clk_p;
        fall  = ~c_s & st_q.clk_p;
        dtr   = d_s ^ st_q.dat_p;
        st_d  = st_q;
        st_d.clk_p = c_s;
        st_d.dat_p = d_s;
        st_d.mode  = cur_mode;
        take  = 1'b0;
        case (cur_mode)
            MODE_RISE:  take = rise;
            MODE_BOTH:  take = rise | fall;
            MODE_MANCH: take = m_emit;
            MODE_EVERY2: begin
                take = rise & st_q.phase;
                if (rise) st_d.phase = ~st_q.phase;
            end
            default:    take = 1'b0;
        endcase
        activity = (cur_mode == MODE_MANCH) ? dtr : (rise | fall);
        if (chg) begin
            take       = 1'b0;
            st_d.phase = 1'b0;
        end
        st_d.valid = take;
        if (take) st_d.bitv = (cur_mode == MODE_MANCH) ? m_bit : d_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{clk_p: 1'b0, dat_p: 1'b0, mode: MODE_RISE,
                              phase: 1'b0, valid: 1'b0, bitv: 1'b0};
        else        st_q <= st_d;
    end

    assign bit_valid = st_q.valid;
    assign bit_data  = st_q.bitv;
endmodule

// File: rtl/sdd_chk.sv
module sdd_chk #(
    parameter int TO_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic [TO_W-1:0] fail_timeout,
    input logic            bit_valid,
    input logic            clk_fail
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bit_valid && !clk_fail));

    // R4
    every2_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && $past(mode) != 2'd3) |=> !bit_valid);

    // R7
    fail_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_fail) |-> ($past(fail_timeout) != '0));

    // R8
    fail_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_timeout == '0 && $past(fail_timeout) == '0) |-> !clk_fail);

    // R9
    valid_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !clk_fail);
endmodule

bind sd_bit_decoder sdd_chk #(.TO_W(TO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fail_timeout(fail_timeout),
    .bit_valid(bit_valid), .clk_fail(clk_fail)
);

// File: tb/sd_bit_decoder_tb.sv
module sd_bit_decoder_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic [1:0]  mode;
    logic [15:0] tmo;
    logic        mclk, mdat;
    logic        bit_valid, bit_data, clk_fail;

    int checks = 0, errors = 0;
    int rx_tot = 0;
    logic [63:0] rxbuf = '0;
    bit finished = 1'b0;

    // {mode, eight bits sent first-to-last from bit 0}
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'b1011_0010}, {2'd0, 8'h5A},
        {2'd1, 8'b1100_1010}, {2'd1, 8'h3C},
        {2'd3, 8'b1001_0110}, {2'd3, 8'hE1},
        {2'd2, 8'b1011_0110}, {2'd2, 8'hF0}
    };

    sd_bit_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .fail_timeout(tmo),
        .mod_clk(mclk), .mod_data(mdat),
        .bit_valid(bit_valid), .bit_data(bit_data), .clk_fail(clk_fail)
    );

    always @(posedge clk) begin
        #5;
        if (rst_n && bit_valid) begin
            rxbuf[rx_tot % 64] = bit_data;
            rx_tot = rx_tot + 1;
        end
    end

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic [1:0] m, input logic b);
        case (m)
            2'd0: begin mdat = b; wc(3); mclk = 1; wc(3); mclk = 0; wc(2); end
            2'd1: begin mdat = b; wc(3); mclk = ~mclk; wc(3); end
            2'd3: begin
                mdat = b; wc(2); mclk = 1; wc(2); mclk = 0; wc(2);
                mclk = 1; wc(2); mclk = 0; wc(2);
            end
            default: begin mdat = ~b; wc(8); mdat = b; wc(8); end
        endcase
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        int start;
        logic [7:0] got;
        rst_n = 0; mode = 2'd0; tmo = 16'd500; mclk = 0; mdat = 0;
        wc(3);
        chk(!bit_valid && !clk_fail, "R1 during reset", {bit_valid, clk_fail}, 0);
        rst_n = 1;
        @(posedge clk); #5;
        chk(!bit_valid && !clk_fail, "R1 after release", {bit_valid, clk_fail}, 0);
        wc(4);

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < 8; v++) begin
            logic [1:0] m;
            logic [7:0] pat;
            m = VEC[v][9:8];
            pat = VEC[v][7:0];
            mclk = 0; mdat = 0; wc(40);
            mode = m; wc(6);
            start = rx_tot;
            if (m == 2'd2) for (int p = 0; p < 3; p++) send_bit(m, 1'b1);
            for (int i = 0; i < 8; i++) send_bit(m, pat[i]);
            wc(8);
            for (int i = 0; i < 8; i++) got[i] = rxbuf[(start + i) % 64];
            chk((rx_tot - start == 8) && (got == pat),
                m == 2'd0 ? "R2 rise" : m == 2'd1 ? "R3 both" :
                m == 2'd3 ? "R4 every2" : "R5 manchester",
                (rx_tot - start) * 256 + got, 8 * 256 + pat);
        end

        // R6: long gap drops lock, following short spacing yields nothing
        wc(60);
        start = rx_tot;
        send_bit(2'd2, 1'b1); send_bit(2'd2, 1'b1);
        wc(8);
        chk(rx_tot == start, "R6 lock drop", rx_tot - start, 0);

        // R4: re-arm on mode change
        mode = 2'd3; mclk = 0; mdat = 1; wc(6);
        mclk = 1; wc(3); mclk = 0; wc(3);
        mode = 2'd0; wc(4); mode = 2'd3; wc(4);
        start = rx_tot;
        mdat = 1; wc(2); mclk = 1; wc(2); mclk = 0; wc(2);
        mdat = 0; wc(2); mclk = 1; wc(2); mclk = 0; wc(6);
        chk(rx_tot - start == 1 && rxbuf[start % 64] == 1'b0, "R4 rearm",
            (rx_tot - start) * 2 + rxbuf[start % 64], 2);

        // R7: clock stops, failure raised, then cleared by an edge
        mode = 2'd0; tmo = 16'd30; mclk = 0; wc(60);
        chk(clk_fail == 1'b1, "R7 fail raised", clk_fail, 1);
        mclk = 1; wc(6);
        chk(clk_fail == 1'b0, "R7 fail cleared", clk_fail, 0);

        // R5 R7: in Manchester mode clock toggles neither yield bits nor count as activity
        mode = 2'd2; mdat = 0; wc(4);
        start = rx_tot;
        for (int k = 0; k < 30; k++) begin mclk = ~mclk; wc(3); end
        chk(rx_tot == start, "R5 clock ignored", rx_tot - start, 0);
        chk(clk_fail == 1'b1, "R7 manchester fail", clk_fail, 1);

        // R8: timeout zero never fails
        mode = 2'd0; tmo = 16'd0; mclk = 0; wc(100);
        chk(clk_fail == 1'b0, "R8 disabled", clk_fail, 0);

        report();
    end
endmodule